// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block makes the control decisions for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle the datapath presents the instruction sitting in decode: its class, its destination index and its two source indices. The block keeps its own record of the class and destination of the older instructions in execute, memory and writeback. From this record it decides whether decode must wait, whether a bubble enters the decode/execute register, which younger slots are squashed, and which bypass path feeds each operand of the instruction in execute.

A static mode input chooses the policy. With forwarding off, a dependent instruction waits in decode until its producer has left writeback. With forwarding on, only a load followed by a consumer costs a wait, and that wait is one cycle. A taken conditional branch is resolved in execute and squashes the two younger slots. A jump is recognised in decode and squashes the one slot in fetch. Four saturating counters record cycles, retired instructions, stall cycles and squashed instructions, so throughput can be worked out as retired divided by cycles.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With `fwd_en`=0, a decode instruction that reads a nonzero register written by a valid producer in execute, memory or writeback stalls. A dependency on the immediately older instruction costs exactly three stall cycles. `fwd_a` and `fwd_b` stay 0 in this mode.
- R2: With `fwd_en`=1, a dependency on a non-load producer never stalls. Each operand select of the execute instruction is 1 when the memory-stage producer matches, 2 when the writeback-stage producer matches, and 0 otherwise.
- R3: With `fwd_en`=1, a consumer directly behind a load stalls for exactly one cycle. It then reaches execute with select 2.
- R4: Class codes: 0 empty, 1 reg-reg ALU (rs1, rs2, rd), 2 ALU immediate (rs1, rd), 3 load (rs1, rd), 4 store (rs1, rs2), 5 branch (rs1, rs2), 6 jump (rd). Unused source fields and x0 never cause a stall. Store and branch never act as producers.
- R5: While `stall`=1, `bubble` is also 1, the fetch side must hold, and each such cycle adds one to `stall_cnt`.
- R6: A valid branch in execute with `ex_br_taken`=1 raises `kill_id`, `kill_if` and `bubble`. This overrides any stall in the same cycle, and the squashed decode instruction is never retired.
- R7: A valid jump in decode raises `kill_if` only and never stalls.
- R8: `cyc_cnt` counts every cycle out of reset. `ret_cnt` counts instructions leaving writeback. `kill_cnt` adds one for each squashed slot whose valid flag (`id_valid`, `if_valid`) is set.
- R9: Synchronous reset clears all counters and the stage record. Counters saturate at their maximum instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fwd_en | input | 1 | Policy select: 1 enables forwarding |
| if_valid | input | 1 | Fetch slot holds an instruction |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_cls | input | 3 | Decode instruction class (R4 codes) |
| id_rd | input | REG_W | Decode destination index |
| id_rs1 | input | REG_W | Decode first source index |
| id_rs2 | input | REG_W | Decode second source index |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Load an empty slot into decode/execute |
| kill_if | output | 1 | Squash the fetch slot |
| kill_id | output | 1 | Squash the decode slot |
| fwd_a | output | 2 | Operand A source for execute |
| fwd_b | output | 2 | Operand B source for execute |
| cyc_cnt | output | CNT_W | Cycle counter |
| ret_cnt | output | CNT_W | Retired instruction counter |
| stall_cnt | output | CNT_W | Stall cycle counter |
| kill_cnt | output | CNT_W | Squashed slot counter |

## Verification
A corrupted stage record shows up at the ports at once. A lost or misplaced destination changes `stall` in the very next decode cycle. It also changes the operand selects one or two cycles later, when the consumer reaches execute. A record that advances during a stall or keeps a squashed slot shows up as a wrong stall length or as an extra retirement in `ret_cnt` three cycles after the event. The directed tests therefore check stall length cycle by cycle and then check the counters after the pipeline drains.

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REG_W = 5,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_en,
  input  logic             if_valid,
  input  logic             id_valid,
  input  logic [2:0]       id_cls,
  input  logic [REG_W-1:0] id_rd,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             ex_br_taken,
  output logic             stall,
  output logic             bubble,
  output logic             kill_if,
  output logic             kill_id,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic [CNT_W-1:0] ret_cnt,
  output logic [CNT_W-1:0] stall_cnt,
  output logic [CNT_W-1:0] kill_cnt
);
  localparam logic [2:0] C_ALU = 3'd1, C_ALUI = 3'd2, C_LD = 3'd3,
                         C_ST = 3'd4, C_BR = 3'd5, C_JMP = 3'd6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic uses_a(input logic [2:0] c);
    return c == C_ALU || c == C_ALUI || c == C_LD || c == C_ST || c == C_BR;
  endfunction

  function automatic logic uses_b(input logic [2:0] c);
    return c == C_ALU || c == C_ST || c == C_BR;
  endfunction

  function automatic logic writes(input logic v, input logic [2:0] c,
                                  input logic [REG_W-1:0] d);
    return v && d != '0 && (c == C_ALU || c == C_ALUI || c == C_LD || c == C_JMP);
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [1:0] inc);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W-1){1'b0}}, inc};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  logic             ex_v, mem_v, wb_v;
  logic [2:0]       ex_cls, mem_cls, wb_cls;
  logic [REG_W-1:0] ex_rd, mem_rd, wb_rd, ex_rs1, ex_rs2;

  logic ex_w, mem_w, wb_w;
  assign ex_w  = writes(ex_v, ex_cls, ex_rd);
  assign mem_w = writes(mem_v, mem_cls, mem_rd);
  assign wb_w  = writes(wb_v, wb_cls, wb_rd);

  logic hit_ex, hit_mem, hit_wb;
  assign hit_ex  = ex_w  && ((uses_a(id_cls) && id_rs1 == ex_rd)  || (uses_b(id_cls) && id_rs2 == ex_rd));
  assign hit_mem = mem_w && ((uses_a(id_cls) && id_rs1 == mem_rd) || (uses_b(id_cls) && id_rs2 == mem_rd));
  assign hit_wb  = wb_w  && ((uses_a(id_cls) && id_rs1 == wb_rd)  || (uses_b(id_cls) && id_rs2 == wb_rd));

  logic br_kill, raw;
  assign br_kill = ex_v && ex_cls == C_BR && ex_br_taken;
  assign raw     = fwd_en ? (hit_ex && ex_cls == C_LD) : (hit_ex || hit_mem || hit_wb);

  assign stall   = id_valid && raw && !br_kill;
  assign kill_id = br_kill;
  assign kill_if = br_kill || (id_valid && id_cls == C_JMP);
  assign bubble  = stall || br_kill;

  always_comb begin
    fwd_a = 2'd0;
    fwd_b = 2'd0;
    if (fwd_en && ex_v) begin
      if (uses_a(ex_cls) && mem_w && ex_rs1 == mem_rd)     fwd_a = 2'd1;
      else if (uses_a(ex_cls) && wb_w && ex_rs1 == wb_rd)  fwd_a = 2'd2;
      if (uses_b(ex_cls) && mem_w && ex_rs2 == mem_rd)     fwd_b = 2'd1;
      else if (uses_b(ex_cls) && wb_w && ex_rs2 == wb_rd)  fwd_b = 2'd2;
    end
  end

  logic [1:0] kill_inc;
  assign kill_inc = {1'b0, br_kill && id_valid} + {1'b0, kill_if && if_valid};

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_v <= 1'b0; mem_v <= 1'b0; wb_v <= 1'b0;
      ex_cls <= '0; mem_cls <= '0; wb_cls <= '0;
      ex_rd <= '0; mem_rd <= '0; wb_rd <= '0;
      ex_rs1 <= '0; ex_rs2 <= '0;
      cyc_cnt <= '0; ret_cnt <= '0; stall_cnt <= '0; kill_cnt <= '0;
    end else begin
      ex_v   <= id_valid && !bubble && id_cls != 3'd0;
      ex_cls <= bubble ? 3'd0 : id_cls;
      ex_rd  <= id_rd;
      ex_rs1 <= id_rs1;
      ex_rs2 <= id_rs2;
      mem_v <= ex_v;   mem_cls <= ex_cls;   mem_rd <= ex_rd;
      wb_v  <= mem_v;  wb_cls  <= mem_cls;  wb_rd  <= mem_rd;
      cyc_cnt   <= sat_add(cyc_cnt, 2'd1);
      ret_cnt   <= sat_add(ret_cnt, {1'b0, wb_v});
      stall_cnt <= sat_add(stall_cnt, {1'b0, stall});
      kill_cnt  <= sat_add(kill_cnt, kill_inc);
    end
  end
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             fwd_en,
  input logic [4:0]       id_rs1,
  input logic [4:0]       id_rs2,
  input logic             stall,
  input logic             bubble,
  input logic             kill_if,
  input logic             kill_id,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [CNT_W-1:0] kill_cnt
);
  // R1
  nofwd_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !fwd_en |-> (fwd_a == 2'd0 && fwd_b == 2'd0));
  // R3
  load_stall_once_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && stall) |=> !stall);
  // R4
  x0_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (id_rs1 != 5'd0 || id_rs2 != 5'd0));
  // R5
  stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (bubble && !kill_id));
  // R6
  kill_wins_chk: assert property (@(posedge clk) disable iff (rst)
    kill_id |-> (!stall && bubble && kill_if));
  // R8
  cyc_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc_cnt >= $past(cyc_cnt));
  // R8
  kill_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, kill_cnt} >= {1'b0, $past(kill_cnt)} &&
              {1'b0, kill_cnt} <= {1'b0, $past(kill_cnt)} + 2));
endmodule

bind pipe_hazard_ctrl hazard_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fwd_en(fwd_en), .id_rs1(id_rs1), .id_rs2(id_rs2),
  .stall(stall), .bubble(bubble), .kill_if(kill_if), .kill_id(kill_id),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .cyc_cnt(cyc_cnt), .kill_cnt(kill_cnt)
);

// File: tb/pipe_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwd_en = 1'b0, if_valid = 1'b0, id_valid = 1'b0, ex_br_taken = 1'b0;
  logic [2:0] id_cls = '0;
  logic [4:0] id_rd = '0, id_rs1 = '0, id_rs2 = '0;
  logic stall, bubble, kill_if, kill_id;
  logic [1:0] fwd_a, fwd_b;
  logic [31:0] cyc_cnt, ret_cnt, stall_cnt, kill_cnt;
  logic n_stall, n_bubble, n_kif, n_kid;
  logic [1:0] n_fa, n_fb;
  logic [2:0] n_cyc, n_ret, n_stc, n_kc;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pipe_hazard_ctrl u_pipe_hazard_ctrl (
    .clk(clk), .rst(rst), .fwd_en(fwd_en), .if_valid(if_valid), .id_valid(id_valid),
    .id_cls(id_cls), .id_rd(id_rd), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_br_taken(ex_br_taken), .stall(stall), .bubble(bubble), .kill_if(kill_if),
    .kill_id(kill_id), .fwd_a(fwd_a), .fwd_b(fwd_b), .cyc_cnt(cyc_cnt),
    .ret_cnt(ret_cnt), .stall_cnt(stall_cnt), .kill_cnt(kill_cnt));

  pipe_hazard_ctrl #(.CNT_W(3)) u_pipe_hazard_ctrl_narrow (
    .clk(clk), .rst(rst), .fwd_en(1'b0), .if_valid(1'b0), .id_valid(1'b0),
    .id_cls(3'd0), .id_rd(5'd0), .id_rs1(5'd0), .id_rs2(5'd0),
    .ex_br_taken(1'b0), .stall(n_stall), .bubble(n_bubble), .kill_if(n_kif),
    .kill_id(n_kid), .fwd_a(n_fa), .fwd_b(n_fb), .cyc_cnt(n_cyc),
    .ret_cnt(n_ret), .stall_cnt(n_stc), .kill_cnt(n_kc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic [2:0] c, input logic [4:0] d, input logic [4:0] a,
                     input logic [4:0] b);
    id_valid = 1'b1; id_cls = c; id_rd = d; id_rs1 = a; id_rs2 = b;
  endtask

  task automatic idle();
    id_valid = 1'b0; id_cls = 3'd0; id_rd = '0; id_rs1 = '0; id_rs2 = '0;
    if_valid = 1'b0; ex_br_taken = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk); rst = 1'b1; fwd_en = mode; idle();
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_counters();
    do_reset(1'b0);
    #1;
    chk("R9 cyc clear", cyc_cnt, 0);
    chk("R9 stall clear", {31'd0, stall}, 0);
    repeat (5) @(negedge clk);
    chk("R8 cyc count", cyc_cnt, 5);
    chk("R8 ret idle", ret_cnt, 0);
    chk("R9 narrow before sat", {29'd0, n_cyc}, 5);
    repeat (5) @(negedge clk);
    chk("R9 narrow saturates", {29'd0, n_cyc}, 7);
  endtask

  task automatic t_nofwd_raw();
    do_reset(1'b0);
    @(negedge clk); put(3'd1, 5'd3, 5'd1, 5'd2); #1;
    chk("R1 producer no stall", {31'd0, stall}, 0);
    @(negedge clk); put(3'd1, 5'd4, 5'd3, 5'd0); #1;
    chk("R1 stall ex", {31'd0, stall}, 1);
    chk("R5 bubble", {31'd0, bubble}, 1);
    @(negedge clk); #1;
    chk("R1 stall mem", {31'd0, stall}, 1);
    chk("R1 fwd off", {30'd0, fwd_a}, 0);
    @(negedge clk); #1;
    chk("R1 stall wb", {31'd0, stall}, 1);
    @(negedge clk); #1;
    chk("R1 released", {31'd0, stall}, 0);
    @(negedge clk); idle(); #1;
    chk("R1 fwd off b", {30'd0, fwd_b}, 0);
    repeat (5) @(negedge clk);
    chk("R5 stall count", stall_cnt, 3);
    chk("R8 retired", ret_cnt, 2);
  endtask

  task automatic t_fwd_paths();
    do_reset(1'b1);
    @(negedge clk); put(3'd1, 5'd3, 5'd1, 5'd2);
    @(negedge clk); put(3'd1, 5'd5, 5'd3, 5'd3); #1;
    chk("R2 no stall alu dep", {31'd0, stall}, 0);
    @(negedge clk); idle(); #1;
    chk("R2 fwd_a mem", {30'd0, fwd_a}, 1);
    chk("R2 fwd_b mem", {30'd0, fwd_b}, 1);
    @(negedge clk); put(3'd1, 5'd6, 5'd1, 5'd2);
    @(negedge clk); put(3'd2, 5'd7, 5'd0, 5'd0);
    @(negedge clk); put(3'd1, 5'd8, 5'd6, 5'd7); #1;
    chk("R2 no stall two", {31'd0, stall}, 0);
    @(negedge clk); idle(); #1;
    chk("R2 fwd_a wb", {30'd0, fwd_a}, 2);
    chk("R2 fwd_b mem2", {30'd0, fwd_b}, 1);
    @(negedge clk); put(3'd1, 5'd9, 5'd1, 5'd2);
    @(negedge clk); put(3'd1, 5'd9, 5'd1, 5'd2);
    @(negedge clk); put(3'd1, 5'd10, 5'd9, 5'd0);
    @(negedge clk); idle(); #1;
    chk("R2 younger wins", {30'd0, fwd_a}, 1);
    chk("R2 no src b", {30'd0, fwd_b}, 0);
    chk("R2 stall count", stall_cnt, 0);
  endtask

  task automatic t_load_use();
    do_reset(1'b1);
    @(negedge clk); put(3'd3, 5'd3, 5'd1, 5'd0);
    @(negedge clk); put(3'd1, 5'd4, 5'd3, 5'd0); #1;
    chk("R3 load stall", {31'd0, stall}, 1);
    @(negedge clk); #1;
    chk("R3 one cycle only", {31'd0, stall}, 0);
    @(negedge clk); idle(); #1;
    chk("R3 fwd from wb", {30'd0, fwd_a}, 2);
    chk("R3 stall count", stall_cnt, 1);
  endtask

  task automatic t_x0_nonproducers();
    do_reset(1'b0);
    @(negedge clk); put(3'd1, 5'd0, 5'd1, 5'd2);
    @(negedge clk); put(3'd4, 5'd4, 5'd0, 5'd2); #1;
    chk("R4 x0 no producer", {31'd0, stall}, 0);
    @(negedge clk); put(3'd5, 5'd6, 5'd1, 5'd2); #1;
    chk("R4 branch reads", {31'd0, stall}, 0);
    @(negedge clk); put(3'd1, 5'd7, 5'd4, 5'd6); #1;
    chk("R4 store branch not producers", {31'd0, stall}, 0);
    @(negedge clk); put(3'd2, 5'd8, 5'd0, 5'd7); #1;
    chk("R4 addi ignores rs2", {31'd0, stall}, 0);
    @(negedge clk); put(3'd6, 5'd9, 5'd9, 5'd9); #1;
    chk("R7 jump never stalls", {31'd0, stall}, 0);
    @(negedge clk); put(3'd1, 5'd10, 5'd9, 5'd0); #1;
    chk("R4 jump is producer", {31'd0, stall}, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_branch_kill();
    do_reset(1'b0);
    @(negedge clk); put(3'd1, 5'd5, 5'd1, 5'd2);
    @(negedge clk); put(3'd5, 5'd0, 5'd1, 5'd2); #1;
    chk("R6 branch no stall", {31'd0, stall}, 0);
    @(negedge clk); put(3'd1, 5'd3, 5'd5, 5'd0); if_valid = 1'b1; ex_br_taken = 1'b1; #1;
    chk("R6 kill over stall", {31'd0, stall}, 0);
    chk("R6 kill_id", {31'd0, kill_id}, 1);
    chk("R6 kill_if", {31'd0, kill_if}, 1);
    chk("R6 bubble", {31'd0, bubble}, 1);
    @(negedge clk); idle(); #1;
    chk("R6 kill count", kill_cnt, 2);
    repeat (5) @(negedge clk);
    chk("R6 killed not retired", ret_cnt, 2);
  endtask

  task automatic t_jump_kill();
    do_reset(1'b1);
    @(negedge clk); put(3'd6, 5'd1, 5'd0, 5'd0); if_valid = 1'b1; #1;
    chk("R7 kill_if", {31'd0, kill_if}, 1);
    chk("R7 no kill_id", {31'd0, kill_id}, 0);
    chk("R7 no bubble", {31'd0, bubble}, 0);
    @(negedge clk); put(3'd6, 5'd2, 5'd0, 5'd0); if_valid = 1'b0; #1;
    chk("R7 kill_if empty", {31'd0, kill_if}, 1);
    @(negedge clk); idle(); #1;
    chk("R8 kill only valid", kill_cnt, 1);
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got 0, expected 1 (run finished)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_counters();
    t_nofwd_raw();
    t_fwd_paths();
    t_load_use();
    t_x0_nonproducers();
    t_branch_kill();
    t_jump_kill();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule